// File: doc/BRIEF.md
# Serial Firmware-Memory Write Target

This block sits on the device side of a one-wire, bit-serial firmware memory bus and accepts memory write cycles. It samples a frame strobe and a single data line on the falling clock edge. It recognises the start code and checks the device-select field against its configured ID. It then assembles a 28-bit start address and a burst-size code. The payload is turned into bytes, and each byte leaves on a plain write-strobe interface together with its address.

When the payload has arrived, the block lets the host finish its half of the bus turnaround. It then drives the ready-sync acknowledgement, drives its own turnaround ones and releases the line. The host may pause the payload at any point by pulling the frame strobe low. Cycles with another start code, another device ID or an illegal size code leave the block idle and produce no writes.

Top module: `fw_serial_wr_target`

## Requirements
- R1: While `rst_n` is low and after reset, `lad_oe` and `wr_en` are 0.
- R2: A cycle begins only at the first falling edge with `frame_n` high after at least four falling edges with `frame_n` low. The last four low-strobe bits, first bit = bit 0, must form 4'b1110 (sent as 0,1,1,1); any other code is ignored.
- R3: The next four bits, bit 0 first, are the device select. The cycle is served only if they equal {3'b000, `id_sel`}; otherwise it is ignored.
- R4: The next 28 bits form the address as seven nibbles, A27..A24 first and A3..A0 last, each nibble bit 0 first.
- R5: The next four bits, bit 0 first, are the size code. 0,1,2,4,7,12,13,14 give 1,2,4,16,128,4096,65536 and 1048576 payload bytes.
- R6: Any other size code ends the cycle with no write and no line drive; the block then waits for a new start.
- R7: Payload bytes arrive bit 0 first. When the falling edge samples bit 7 of byte k, `wr_en` goes high for exactly one clock with `wr_data` = byte k and `wr_addr` = (address + k) mod 2^28.
- R8: During the payload, a falling edge with `frame_n` low is a wait state; its data bit is discarded and bit collection resumes when `frame_n` is high.
- R9: After the last payload bit the block releases the line for 8 clocks. It then drives 0 for 4 clocks (`lad_oe`=1, `lad_out`=0) and 1 for 4 clocks (`lad_oe`=1, `lad_out`=1), then releases the line. `lad_oe` is 0 at all other times.
- R10: After the release the block is idle and accepts a new cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| id_sel | input | 1 | Configured device ID (0 or 1) |
| frame_n | input | 1 | Active-low frame strobe |
| lad_in | input | 1 | Data line as seen at the pin |
| lad_out | output | 1 | Value driven onto the data line |
| lad_oe | output | 1 | Data line drive enable |
| wr_en | output | 1 | One-clock write strobe per received byte |
| wr_addr | output | 28 | Address of the byte being written |
| wr_data | output | 8 | Byte being written |

## Verification
The assertions assume that the host keeps `frame_n` high outside the start and the payload wait states, and that `id_sel` changes only while the block is idle. The stimulus keeps to both rules. It changes `id_sel` only between cycles, and it inserts random wait states only in payload windows of cycles that are meant to be served. The ignored-cycle cases send their fields with the strobe high. Because of this, no stray low-strobe run can look like a start.

// File: rtl/fw_serial_wr_target.sv
module fw_serial_wr_target #(
  parameter int ADDR_W = 28,
  parameter int IDX_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_sel,
  input  logic              frame_n,
  input  logic              lad_in,
  output logic              lad_out,
  output logic              lad_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int NIBS = ADDR_W / 4;
  localparam int ABITS = NIBS * 4;
  localparam logic [3:0] START_WR = 4'b1110;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_ADDR, S_SIZE, S_DATA, S_HTAR, S_SYNC, S_DTAR0, S_DTAR1
  } st_t;

  st_t               st;
  logic [5:0]        cnt;
  logic [3:0]        nib;
  logic [2:0]        lowcnt;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [6:0]        dsh;
  logic [3:0]        nib_nx;
  logic              sz_ok;
  logic [4:0]        sz_lg;

  assign nib_nx  = {lad_in, nib[3:1]};
  assign lad_oe  = (st == S_SYNC) || (st == S_DTAR0);
  assign lad_out = (st == S_DTAR0);

  always_comb begin
    sz_ok = 1'b1;
    case (nib_nx)
      4'd0:    sz_lg = 5'd0;
      4'd1:    sz_lg = 5'd1;
      4'd2:    sz_lg = 5'd2;
      4'd4:    sz_lg = 5'd4;
      4'd7:    sz_lg = 5'd7;
      4'd12:   sz_lg = 5'd12;
      4'd13:   sz_lg = 5'd16;
      4'd14:   sz_lg = 5'd20;
      default: begin sz_lg = 5'd0; sz_ok = 1'b0; end
    endcase
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      nib      <= '0;
      lowcnt   <= '0;
      addr     <= '0;
      idx      <= '0;
      last_idx <= '0;
      dsh      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en  <= 1'b0;
      lowcnt <= frame_n ? 3'd0 : ((lowcnt == 3'd4) ? 3'd4 : lowcnt + 3'd1);
      case (st)
        S_IDLE: begin
          if (!frame_n) nib <= nib_nx;
          else if (lowcnt == 3'd4 && nib == START_WR) begin
            nib <= nib_nx;
            cnt <= 6'd1;
            st  <= S_ID;
          end
        end
        S_ID: begin
          nib <= nib_nx;
          cnt <= cnt + 6'd1;
          if (cnt == 6'd3) begin
            cnt <= '0;
            st  <= (nib_nx == {3'b000, id_sel}) ? S_ADDR : S_IDLE;
          end
        end
        S_ADDR: begin
          nib <= nib_nx;
          cnt <= cnt + 6'd1;
          if (cnt[1:0] == 2'd3) addr <= {addr[ADDR_W-5:0], nib_nx};
          if (cnt == 6'(ABITS - 1)) begin
            cnt <= '0;
            st  <= S_SIZE;
          end
        end
        S_SIZE: begin
          nib <= nib_nx;
          cnt <= cnt + 6'd1;
          if (cnt == 6'd3) begin
            cnt      <= '0;
            idx      <= '0;
            last_idx <= (IDX_W'(1) << sz_lg) - IDX_W'(1);
            st       <= sz_ok ? S_DATA : S_IDLE;
          end
        end
        S_DATA: begin
          if (frame_n) begin
            dsh <= {lad_in, dsh[6:1]};
            cnt <= cnt + 6'd1;
            if (cnt == 6'd7) begin
              cnt     <= '0;
              wr_en   <= 1'b1;
              wr_data <= {lad_in, dsh};
              wr_addr <= addr + ADDR_W'(idx);
              idx     <= idx + IDX_W'(1);
              if (idx == last_idx) st <= S_HTAR;
            end
          end
        end
        S_HTAR: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd7) begin cnt <= '0; st <= S_SYNC; end
        end
        S_SYNC: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd3) begin cnt <= '0; st <= S_DTAR0; end
        end
        S_DTAR0: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd3) begin cnt <= '0; st <= S_DTAR1; end
        end
        S_DTAR1: begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd3) begin cnt <= '0; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_wr_pulse_r7: assert property (@(negedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_wr_from_data_r7: assert property (@(negedge clk) disable iff (!rst_n)
    wr_en |-> $past(st) == S_DATA);

  p_stall_hold_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_DATA && !frame_n) |=> (!wr_en && $stable(idx)));

  p_sync_first_r9: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (!lad_out && $past(st) == S_HTAR));

  p_release_r9: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(lad_oe) |-> $past(lad_out));

  p_abort_r6: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_SIZE && cnt == 6'd3 && !sz_ok) |=> (st == S_IDLE && !wr_en && !lad_oe));

  p_reset_r1: assert property (@(negedge clk)
    !rst_n |=> (!wr_en && !lad_oe));
endmodule

// File: tb/fw_serial_wr_target_tb.sv
module fw_serial_wr_target_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_sel = 1'b0;
  logic frame_n = 1'b1;
  logic lad_in = 1'b1;
  logic lad_out, lad_oe, wr_en;
  logic [27:0] wr_addr;
  logic [7:0] wr_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] pay [0:4095];
  logic [27:0] exp_base;
  int exp_n = 0;
  int wcnt = 0;

  always #10 clk = ~clk;

  fw_serial_wr_target u_dut (
    .clk(clk), .rst_n(rst_n), .id_sel(id_sel), .frame_n(frame_n),
    .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_of(input logic [3:0] code);
    case (code)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 4;
      4'd4: return 16;
      4'd7: return 128;
      4'd12: return 4096;
      4'd13: return 65536;
      4'd14: return 1048576;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      if (wcnt >= exp_n) chk(1'b0, "R7 unexpected write", wcnt, exp_n);
      else begin
        chk(wr_addr == 28'(exp_base + 28'(wcnt)), "R7 address", wr_addr, 28'(exp_base + 28'(wcnt)));
        chk(wr_data == pay[wcnt], "R7 data", wr_data, pay[wcnt]);
      end
      wcnt++;
    end
  end

  task automatic drive(input logic f, input logic b);
    @(posedge clk);
    chk(!lad_oe, "R9 line released", lad_oe, 0);
    frame_n <= f;
    lad_in  <= b;
  endtask

  task automatic send_nib(input logic [3:0] v, input logic f);
    for (int i = 0; i < 4; i++) drive(f, v[i]);
  endtask

  task automatic line_check(input logic oe, input logic val, input string req);
    @(posedge clk);
    chk(lad_oe == oe, req, lad_oe, oe);
    if (oe) chk(lad_out == val, req, lad_out, val);
    frame_n <= 1'b1;
    lad_in  <= 1'b1;
  endtask

  task automatic run_cycle(input logic [3:0] start, input logic [3:0] id, input logic [27:0] addr,
                           input logic [3:0] code, input int stall_pct, input int pre_low,
                           input logic ok, input string req);
    int n;
    n = n_of(code);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    exp_base = addr;
    exp_n = ok ? n : 0;
    wcnt = 0;
    for (int i = 0; i < pre_low; i++) drive(1'b0, 1'($urandom));
    send_nib(start, 1'b0);
    send_nib(id, 1'b1);
    for (int k = 6; k >= 0; k--) send_nib(addr[k*4 +: 4], 1'b1);
    send_nib(code, 1'b1);
    if (n == 0) for (int i = 0; i < 8; i++) drive(1'b1, 1'($urandom));
    for (int by = 0; by < n; by++)
      for (int b = 0; b < 8; b++) begin
        while (int'($urandom % 100) < stall_pct) drive(1'b0, 1'($urandom));
        drive(1'b1, pay[by][b]);
      end
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b1);
    if (ok) begin
      for (int i = 0; i < 4; i++) line_check(1'b1, 1'b0, "R9 ready-sync zeros");
      for (int i = 0; i < 4; i++) line_check(1'b1, 1'b1, "R9 driven ones");
      for (int i = 0; i < 4; i++) line_check(1'b0, 1'b0, "R9 released after turnaround");
    end else begin
      for (int i = 0; i < 12; i++) line_check(1'b0, 1'b0, req);
    end
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1);
    chk(wcnt == exp_n, ok ? "R5 R7 byte count" : req, wcnt, exp_n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned s;
    logic [3:0] codes [0:4];
    codes[0] = 4'd0; codes[1] = 4'd1; codes[2] = 4'd2; codes[3] = 4'd4; codes[4] = 4'd7;
    s = $urandom(32'd4242);
    repeat (4) @(posedge clk);
    chk(!lad_oe && !wr_en, "R1 reset outputs", {lad_oe, wr_en}, 0);
    @(posedge clk); rst_n <= 1'b1;
    repeat (3) @(posedge clk);
    chk(!lad_oe && !wr_en, "R1 after reset", {lad_oe, wr_en}, 0);

    run_cycle(4'b1110, 4'd0, 28'h1234567, 4'd0, 0, 0, 1'b1, "R4 single byte");
    run_cycle(4'b1110, 4'd0, 28'hFFFFFFE, 4'd2, 0, 0, 1'b1, "R7 address wrap");
    run_cycle(4'b1110, 4'd0, 28'h0A5C3F0, 4'd4, 0, 3, 1'b1, "R2 long low before start");
    run_cycle(4'b0101, 4'd0, 28'h0000100, 4'd1, 0, 0, 1'b0, "R2 wrong start ignored");
    run_cycle(4'b1110, 4'd1, 28'h0000200, 4'd1, 0, 0, 1'b0, "R3 wrong ID ignored");
    run_cycle(4'b1110, 4'd0, 28'h0000300, 4'd3, 0, 0, 1'b0, "R6 illegal size 3");
    run_cycle(4'b1110, 4'd0, 28'h0000400, 4'd15, 0, 0, 1'b0, "R6 illegal size 15");
    run_cycle(4'b1110, 4'd0, 28'h7654321, 4'd7, 40, 0, 1'b1, "R8 heavy stalls, R10 recovery");
    id_sel = 1'b1;
    run_cycle(4'b1110, 4'd0, 28'h0000500, 4'd0, 0, 0, 1'b0, "R3 ID 0 ignored when configured 1");
    run_cycle(4'b1110, 4'd1, 28'h0ABCDEF, 4'd12, 0, 0, 1'b1, "R5 4K burst");
    for (int r = 0; r < 16; r++) begin
      id_sel = 1'($urandom);
      run_cycle(4'b1110, {3'b000, id_sel}, 28'($urandom), codes[$urandom % 5], 20,
                int'($urandom % 3), 1'b1, "R10 random cycle");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule